// File: doc/BRIEF.md
# Tree Network Up/Down Route Sequencer

This block works out the path a packet takes through a k-ary tree network, with k a power of two. A request carries a source leaf address and a destination leaf address. Each address is a string of radix-k digits that spells the path from the root down to the leaf. The block finds the highest digit position at which the two addresses differ. It reports how many levels the packet has to climb to reach the nearest common ancestor of the two leaves.

Once a request is accepted, the block issues the route one hop per step handshake. It first issues the climb hops. It then issues one descend hop per level, and each descend hop names the child port taken from the destination address, highest of the needed digits first. When the two addresses are equal, the packet stays at its leaf: the block issues a single local-delivery step. The route sequence is blocking, so a new request is taken only after the final step has been consumed.

Top module: `tree_route_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `step_valid` is 0.
- R2: Digit d of an address occupies bits [d*P +: P], where P = log2(RADIX), and digit LEVELS-1 is nearest the root. `climb` equals i+1, where i is the highest digit index at which src and dst differ. `climb` is 0 when src equals dst. It holds that value while steps are presented.
- R3: A route with climb h > 0 begins with exactly h steps of kind UP (`step_kind` = 2'b01) with `step_port` = 0.
- R4: The UP steps are followed by exactly h steps of kind DOWN (`step_kind` = 2'b10). The j-th DOWN step (j from 0) carries dst digit h-1-j on `step_port`.
- R5: `step_last` is 1 on the final step of a route and 0 on every other step.
- R6: When src equals dst, the route is a single step of kind LOCAL (`step_kind` = 2'b11) with `step_last` = 1 and `climb` = 0.
- R7: `req_ready` is 0 from the accepting edge until the final step is accepted. A request held during that time is ignored. `req_ready` returns to 1 in the cycle after the final step's handshake.
- R8: While `step_valid` is 1 and `step_ready` is 0, the step outputs and `climb` stay unchanged.
- R9: Following the issued steps from the source leaf, where UP moves to the parent and DOWN(p) moves to child p, ends at the destination leaf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Route request present |
| req_ready | output | 1 | Block can take a request |
| req_src | input | LEVELS*log2(RADIX) | Source leaf address |
| req_dst | input | LEVELS*log2(RADIX) | Destination leaf address |
| step_valid | output | 1 | A route step is presented |
| step_ready | input | 1 | Consumer takes the step |
| step_kind | output | 2 | 01 UP, 10 DOWN, 11 LOCAL |
| step_port | output | log2(RADIX) | Child port for DOWN steps, else 0 |
| step_last | output | 1 | Final step of the route |
| climb | output | clog2(LEVELS+1) | Levels to climb for the current route |

## Verification
Two events can land in the same cycle: the handshake on the final step and a request waiting at the input. The bench keeps `req_valid` high with unrelated addresses for the whole route. It then checks that `req_ready` stays low and that no step belongs to the waiting request. It also checks that `req_ready` comes back exactly in the cycle after the final step's handshake. Random back-pressure on `step_ready` adds the case where the final step is stalled. Every source and destination pair is walked through a model of the tree to confirm the packet arrives at the destination leaf.

// File: rtl/tree_route_unit.sv
module tree_route_unit #(
  parameter int RADIX  = 4,
  parameter int LEVELS = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic [LEVELS*$clog2(RADIX)-1:0]      req_src,
  input  logic [LEVELS*$clog2(RADIX)-1:0]      req_dst,
  output logic                                 step_valid,
  input  logic                                 step_ready,
  output logic [1:0]                           step_kind,
  output logic [$clog2(RADIX)-1:0]             step_port,
  output logic                                 step_last,
  output logic [$clog2(LEVELS+1)-1:0]          climb
);
  localparam int PW = $clog2(RADIX);
  localparam int AW = LEVELS * PW;
  localparam int CW = $clog2(LEVELS + 1);
  localparam int IW = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  localparam logic [1:0] K_UP    = 2'b01;
  localparam logic [1:0] K_DOWN  = 2'b10;
  localparam logic [1:0] K_LOCAL = 2'b11;

  logic          busy_q, local_q;
  logic [CW-1:0] up_left_q, climb_q, hops_c;
  logic [IW-1:0] dig_q;
  logic [AW-1:0] dst_q;
  logic [AW-1:0] diff;

  wire accept  = req_valid && req_ready;
  wire fire    = step_valid && step_ready;
  wire in_up   = busy_q && !local_q && (up_left_q != '0);
  wire in_down = busy_q && !local_q && (up_left_q == '0);

  assign diff = req_src ^ req_dst;

  always_comb begin
    hops_c = '0;
    for (int d = 0; d < LEVELS; d++)
      if (diff[d*PW +: PW] != '0) hops_c = CW'(d + 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      local_q   <= 1'b0;
      up_left_q <= '0;
      climb_q   <= '0;
      dig_q     <= '0;
      dst_q     <= '0;
    end else if (accept) begin
      busy_q    <= 1'b1;
      local_q   <= (hops_c == '0);
      up_left_q <= hops_c;
      climb_q   <= hops_c;
      dig_q     <= (hops_c == '0) ? '0 : IW'(hops_c - 1'b1);
      dst_q     <= req_dst;
    end else if (fire) begin
      if (local_q) begin
        busy_q <= 1'b0;
      end else if (in_up) begin
        up_left_q <= up_left_q - 1'b1;
      end else if (dig_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        dig_q <= dig_q - 1'b1;
      end
    end
  end

  assign req_ready  = !busy_q;
  assign step_valid = busy_q;
  assign step_kind  = !busy_q ? 2'b00 : local_q ? K_LOCAL : in_up ? K_UP : K_DOWN;
  assign step_port  = in_down ? dst_q[dig_q*PW +: PW] : '0;
  assign step_last  = busy_q && (local_q || (in_down && dig_q == '0));
  assign climb      = climb_q;

  AST_NO_TAKE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |-> !req_ready); // R7
  AST_STEP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !step_ready) |=> (step_valid && $stable(step_kind) && $stable(step_port)
                                     && $stable(step_last) && $stable(climb))); // R8
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_ready && step_last) |=> (!step_valid && req_ready)); // R7
  AST_LOCAL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_kind == K_LOCAL) |-> (step_last && climb == '0)); // R6
  AST_NO_UP_AFTER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_ready && step_kind == K_DOWN && !step_last) |=> (step_kind == K_DOWN)); // R4
  AST_CLIMB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |-> (climb <= CW'(LEVELS))); // R2
  AST_UP_PORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_kind == K_UP) |-> (step_port == '0 && !step_last)); // R3
endmodule

// File: tb/tree_route_unit_tb.sv
module tree_route_unit_tb;
  localparam int K  = 4;
  localparam int N  = 3;
  localparam int W  = $clog2(K);
  localparam int AW = N * W;
  localparam int CW = $clog2(N + 1);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, step_ready = 0;
  logic [AW-1:0] req_src = '0, req_dst = '0;
  logic req_ready, step_valid, step_last;
  logic [1:0] step_kind;
  logic [W-1:0] step_port;
  logic [CW-1:0] climb;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tree_route_unit #(.RADIX(K), .LEVELS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .step_valid(step_valid), .step_ready(step_ready),
    .step_kind(step_kind), .step_port(step_port), .step_last(step_last), .climb(climb));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_climb(input int a, input int b);
    for (int d = N - 1; d >= 0; d--)
      if (((a >> (d * W)) & (K - 1)) != ((b >> (d * W)) & (K - 1))) return d + 1;
    return 0;
  endfunction

  task automatic run_route(input int a, input int b, input int stall_pct);
    int h, node, depth, nsteps, dcount;
    logic [1:0] pk; logic [W-1:0] pp; logic pl; logic [CW-1:0] pc;
    bit stalled;
    h = exp_climb(a, b);
    @(negedge clk);
    req_valid = 1; req_src = AW'(a); req_dst = AW'(b);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_src = AW'($urandom); req_dst = AW'($urandom);
    node = a; depth = N; nsteps = 0; dcount = 0; stalled = 0;
    pk = 0; pp = 0; pl = 0; pc = 0;
    forever begin
      chk(step_valid && !req_ready, "R7 busy", int'(req_ready), 0);
      if (stalled)
        chk(step_kind == pk && step_port == pp && step_last == pl && climb == pc,
            "R8 hold", int'(step_kind), int'(pk));
      if (nsteps == 0) chk(int'(climb) == h, "R2 climb", int'(climb), h);
      if (h == 0) begin
        chk(step_kind == 2'b11 && step_last, "R6 local", int'(step_kind), 3);
      end else if (nsteps < h) begin
        chk(step_kind == 2'b01 && step_port == 0, "R3 up", int'(step_kind), 1);
      end else begin
        int e = (b >> ((h - 1 - dcount) * W)) & (K - 1);
        chk(step_kind == 2'b10 && int'(step_port) == e, "R4 down", int'(step_port), e);
      end
      chk(step_last == ((h == 0) || (nsteps == 2 * h - 1)), "R5 last",
          int'(step_last), int'((h == 0) || (nsteps == 2 * h - 1)));
      step_ready = ($urandom % 100) >= stall_pct;
      pk = step_kind; pp = step_port; pl = step_last; pc = climb;
      @(posedge clk);
      #1;
      if (step_ready) begin
        stalled = 0;
        if (pk == 2'b01) begin node = node >> W; depth--; end
        else if (pk == 2'b10) begin node = (node << W) | int'(pp); depth++; dcount++; end
        nsteps++;
        if (pl) break;
        if (nsteps > 2 * N + 1) break;
      end else stalled = 1;
      @(negedge clk);
    end
    @(negedge clk);
    step_ready = 0;
    chk(req_ready && !step_valid, "R7 ready after last", int'(req_ready), 1);
    chk(node == b && depth == N, "R9 walk", node, b);
    req_valid = 0;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(req_ready && !step_valid, "R1 reset", int'(step_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !step_valid, "R1 after reset", int'(req_ready), 1);
    run_route(0, 0, 0);
    run_route(0, (1 << AW) - 1, 0);
    run_route(5, 6, 70);
    run_route((1 << AW) - 1, 0, 50);
    for (int a = 0; a < (1 << AW); a++)
      for (int b = 0; b < (1 << AW); b++)
        run_route(a, b, (a + b) % 3 == 0 ? 40 : 0);
    for (int r = 0; r < 200; r++)
      run_route(int'($urandom % (1 << AW)), int'($urandom % (1 << AW)), 60);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule